// File: doc/BRIEF.md
# Serial Divisible-by-Three Detector

This block watches an unsigned binary number that arrives one bit per clock, most significant bit first. It decides, after every accepted bit, whether the value received so far is a multiple of three. It does not store the number. It keeps only the running remainder modulo 3. When a new bit `b` is accepted, the remainder `r` becomes `(2*r + b) mod 3`, because appending a bit doubles the value and then adds the bit.

A qualifying enable input marks the cycles that carry a bit. The remainder stays put in any cycle where the enable is low, so gaps in the stream are allowed. A synchronous, active-high reset starts a new number. An empty stream stands for zero, so after reset the divisible flag is high. The remainder is also brought out as a two-bit binary code so that it can be observed.

Top module: `serial_mod3_detector`

## Requirements
- R1: After a clock edge with `rst` high, `rem_out` is 0 and `div3` is 1.
- R2: On a clock edge with `rst` low and `en` high, `rem_out` changes as follows. From 0, a 0 bit keeps it at 0 and a 1 bit takes it to 1. From 1, a 0 bit takes it to 2 and a 1 bit takes it to 0. From 2, a 0 bit takes it to 1 and a 1 bit keeps it at 2.
- R3: `div3` is 1 exactly when `rem_out` is 0.
- R4: On a clock edge with `rst` low and `en` low, `rem_out` and `div3` keep their values, whatever `ser_bit` is.
- R5: When `rst` and `en` are both high on the same edge, the reset wins and `rem_out` becomes 0.
- R6: After reset, the enabled bits 1, 0, 0, 1 give `div3` values 0, 0, 0, 1 after the successive edges (running values 1, 2, 4, 9).
- R7: For a stream of any length, after each enabled edge `rem_out` equals the binary value of all bits accepted since reset, modulo 3.
- R8: `rem_out` never shows the code 3. Only the binary codes 0, 1 and 2 appear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; a bit is taken on the rising edge |
| rst | input | 1 | Synchronous active-high reset to remainder 0 |
| en | input | 1 | High when `ser_bit` carries a bit to accept |
| ser_bit | input | 1 | Serial data bit, most significant first |
| div3 | output | 1 | High when the value so far is divisible by 3 |
| rem_out | output | 2 | Running remainder modulo 3, binary coded |

## Verification
The block has no tunable parameters, so the bench builds it with its single fixed two-bit remainder encoding. A vector table covers all six transitions, both hold cases and the reset-over-enable collision. A 60-bit pseudo-random stream, with gaps in the enable, is then compared against a wide integer held by the bench and divided by three. This reaches remainder sequences far longer than the table, without any modular shortcut in the bench.

// File: rtl/mod3_pkg.sv
package mod3_pkg;
  localparam int REM_W = 2;
  typedef logic [REM_W-1:0] rem_t;

  localparam rem_t REM_ZERO = 2'd0;
  localparam rem_t REM_ONE  = 2'd1;
  localparam rem_t REM_TWO  = 2'd2;

  // Appending a bit doubles the value and adds the bit; the remainder
  // follows as a three-way table. The unused code falls back to zero.
  function automatic rem_t fold_bit(rem_t r, logic b);
    rem_t n;
    case (r)
      REM_ZERO: n = b ? REM_ONE  : REM_ZERO;
      REM_ONE:  n = b ? REM_ZERO : REM_TWO;
      REM_TWO:  n = b ? REM_TWO  : REM_ONE;
      default:  n = REM_ZERO;
    endcase
    return n;
  endfunction

  function automatic logic is_legal(rem_t r);
    return (r == REM_ZERO) || (r == REM_ONE) || (r == REM_TWO);
  endfunction
endpackage

// File: rtl/mod3_next.sv
module mod3_next
  import mod3_pkg::*;
(
  input  rem_t cur,
  input  logic in_bit,
  output rem_t nxt,
  output logic cur_illegal
);
  always_comb begin
    nxt         = fold_bit(cur, in_bit);
    cur_illegal = !is_legal(cur);
  end
endmodule

// File: rtl/mod3_state.sv
module mod3_state
  import mod3_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  rem_t nxt,
  output rem_t cur
);
  always_ff @(posedge clk) begin
    if (rst)       cur <= REM_ZERO;
    else if (take) cur <= nxt;
  end

  // R1: a reset edge clears the remainder
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> cur == REM_ZERO);

  // R5: reset takes priority over a bit in the same cycle
  a_r5_reset_wins: assert property (@(posedge clk) (rst && take) |=> cur == REM_ZERO);

  // R4: without take, the remainder holds
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(cur));
endmodule

// File: rtl/mod3_flag.sv
module mod3_flag
  import mod3_pkg::*;
(
  input  rem_t       cur,
  output logic       div3,
  output logic [REM_W-1:0] rem_view
);
  always_comb begin
    div3     = (cur == REM_ZERO);
    rem_view = cur;
  end
endmodule

// File: rtl/serial_mod3_detector.sv
module serial_mod3_detector
  import mod3_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       ser_bit,
  output logic       div3,
  output logic [1:0] rem_out
);
  rem_t cur_rem;
  rem_t nxt_rem;
  logic cur_illegal;

  mod3_next u_next (
    .cur         (cur_rem),
    .in_bit      (ser_bit),
    .nxt         (nxt_rem),
    .cur_illegal (cur_illegal)
  );

  mod3_state u_state (
    .clk  (clk),
    .rst  (rst),
    .take (en),
    .nxt  (nxt_rem),
    .cur  (cur_rem)
  );

  mod3_flag u_flag (
    .cur      (cur_rem),
    .div3     (div3),
    .rem_view (rem_out)
  );

  // R2: arithmetic restatement of the step, (2r+b) mod 3
  a_r2_step_arith: assert property (@(posedge clk) disable iff (rst)
    en |=> int'(rem_out) == ((int'($past(rem_out)) * 2 + int'($past(ser_bit))) % 3));

  // R8: the state register never holds the unused code
  a_r8_legal_code: assert property (@(posedge clk) disable iff (rst)
    !cur_illegal);
endmodule

// File: tb/serial_mod3_detector_bench.sv
module serial_mod3_detector_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       ser_bit = 1'b0;
  logic       div3;
  logic [1:0] rem_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  serial_mod3_detector u_serial_mod3_detector (
    .clk(clk), .rst(rst), .en(en), .ser_bit(ser_bit),
    .div3(div3), .rem_out(rem_out)
  );

  // Entry: {rst, en, bit, expected remainder[1:0], expected flag}
  localparam int NV = 18;
  localparam logic [5:0] VEC [NV] = '{
    {3'b011, 2'd1, 1'b0},  // R6 value 1
    {3'b010, 2'd2, 1'b0},  // R6 value 2
    {3'b010, 2'd1, 1'b0},  // R6 value 4
    {3'b011, 2'd0, 1'b1},  // R6 value 9
    {3'b001, 2'd0, 1'b1},  // R4 hold
    {3'b010, 2'd0, 1'b1},  // R2 0 -0-> 0
    {3'b011, 2'd1, 1'b0},  // R2 0 -1-> 1
    {3'b011, 2'd0, 1'b1},  // R2 1 -1-> 0
    {3'b011, 2'd1, 1'b0},
    {3'b000, 2'd1, 1'b0},  // R4 hold
    {3'b010, 2'd2, 1'b0},  // R2 1 -0-> 2
    {3'b011, 2'd2, 1'b0},  // R2 2 -1-> 2
    {3'b010, 2'd1, 1'b0},  // R2 2 -0-> 1
    {3'b011, 2'd0, 1'b1},
    {3'b111, 2'd0, 1'b1},  // R5 reset wins
    {3'b011, 2'd1, 1'b0},
    {3'b000, 2'd1, 1'b0},  // R4 hold
    {3'b011, 2'd0, 1'b1}
  };

  task automatic check(string req, logic [1:0] exp_rem, logic exp_div);
    total++;
    if (rem_out !== exp_rem || div3 !== exp_div) begin
      bad++;
      $display("FAIL %s: rem=%0d div3=%0b expected rem=%0d div3=%0b",
               req, rem_out, div3, exp_rem, exp_div);
    end
  endtask

  task automatic step(logic r, logic e, logic b);
    @(negedge clk);
    rst = r; en = e; ser_bit = b;
    @(posedge clk);
    #2;
  endtask

  initial begin
    longint unsigned value;
    logic [15:0] lfsr;
    int taken;

    step(1'b1, 1'b0, 1'b0);
    check("R1", 2'd0, 1'b1);
    step(1'b1, 1'b1, 1'b1);
    check("R1", 2'd0, 1'b1);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][5], VEC[i][4], VEC[i][3]);
      check(VEC[i][5] ? "R5" : (!VEC[i][4] ? "R4" : (i < 4 ? "R6" : "R2")),
            VEC[i][2:1], VEC[i][0]);
      // R3: the flag must agree with the remainder
      total++;
      if (div3 !== (rem_out == 2'd0)) begin
        bad++;
        $display("FAIL R3: div3=%0b expected %0b", div3, rem_out == 2'd0);
      end
    end

    // R7/R8: long pseudo-random stream against a wide integer
    step(1'b1, 1'b0, 1'b0);
    value = 0;
    lfsr = 16'hACE1;
    taken = 0;
    while (taken < 60) begin
      logic e;
      logic b;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      e = (lfsr[3:1] != 3'b000);
      b = lfsr[7];
      step(1'b0, e, b);
      if (e) begin
        value = value * 2 + longint'(b);
        taken++;
      end
      check("R7", 2'(value % 3), (value % 3) == 0);
      total++;
      if (rem_out == 2'd3) begin
        bad++;
        $display("FAIL R8: rem=%0d expected a code below 3", rem_out);
      end
    end

    // R4: a run of disabled cycles with toggling data changes nothing
    for (int k = 0; k < 6; k++) begin
      step(1'b0, 1'b0, k[0]);
      check("R4", 2'(value % 3), (value % 3) == 0);
    end

    // R1: reset mid-stream
    step(1'b1, 1'b0, 1'b1);
    check("R1", 2'd0, 1'b1);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule